// File: doc/BRIEF.md
# Prescaled PWM Channel with Shadowed Configuration

This block is one PWM output channel programmed through a single 32-bit control word. Two cascaded counters set the output period. A prescaler divides the source clock by `pre + 1`. A period counter then counts `div + 1` of those prescaled ticks. The output is high for the first `hi` prescaled ticks of each period.

Writes never touch the running counters directly. The prescaler, high-duration and period-divider fields go into a shadow copy. A self-clearing update request moves the whole shadow copy into the active set in one step. While the channel runs, this move waits for the end of the current period, so no period is ever cut short or glitched. While the channel is disabled, the move happens at once.

Software starts the channel by writing the enable and update bits together. It keeps the other fields with a read-modify-write. The write port and the read-back word are plain register pins with no handshake, because each write completes in one cycle.

Top module: `pwm_shadow_chan`

## Requirements
- R1: While running, the output period is (pre + 1) × (div + 1) clock cycles. pre, hi and div are the values currently active.
- R2: The output is high for the first min(hi, div + 1) prescaled ticks of each period and low for the rest. With hi = 0 it stays low. With hi ≥ div + 1 it stays high.
- R3: Control word fields: bit 31 is enable, bit 30 is the update request, bits 29:22 are pre (8 bits), bit 21 is reserved and reads 0, bits 20:10 are hi (11 bits), and bits 9:0 are div (10 bits). A read returns the shadow fields, the live enable bit and the pending update flag in these positions.
- R4: A write updates the shadow fields and the enable bit on the next clock edge. The output timing keeps using the active values until an update is committed.
- R5: While running, a pending update is committed at the next period boundary. The period in progress completes with the old values, and the next period uses the new values throughout.
- R6: The update bit reads 1 from the write that sets it until the commit. It reads 0 after the commit. A later write with update = 0 does not cancel a pending update.
- R7: While disabled, the output is low and both counters are held at zero. The output is low in the cycle after a write that clears enable. A pending update is committed on the first edge at which the channel is disabled.
- R8: A write that sets enable and update together commits on the following edge. The first period then starts and runs entirely with the new values.
- R9: A synchronous active-low reset clears every field, the enable bit and the pending flag, and drives the output low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Strobe that writes the control word |
| wr_data | input | 32 | Control word to write |
| rd_data | output | 32 | Read-back of the control word |
| pwm_out | output | 1 | PWM output |

## Verification
The assertions assume that reset is held low during the first clock edge. They also assume that `wr_data` carries known values whenever `wr_en` is high. The bench meets both: it drives reset from time zero, and it changes the write pins only on falling edges, with full words built from explicit field values. The persistence check on a pending update assumes that no new update write arrives in the same cycle. The bench issues such a write only in the case where it exercises the non-cancelling rule, and the assertion antecedent excludes that cycle.

// File: rtl/pwm_shadow_pkg.sv
package pwm_shadow_pkg;
  localparam int WORD_W  = 32;
  localparam int PRE_W   = 8;
  localparam int HI_W    = 11;
  localparam int DIV_W   = 10;
  localparam int EN_BIT  = 31;
  localparam int UPD_BIT = 30;
  localparam int PRE_LSB = 22;
  localparam int RSV_BIT = 21;
  localparam int HI_LSB  = 10;
  localparam int DIV_LSB = 0;
  localparam int CMP_W   = (HI_W > DIV_W) ? HI_W : DIV_W;

  typedef struct packed {
    logic [PRE_W-1:0] pre;
    logic [HI_W-1:0]  hi;
    logic [DIV_W-1:0] div;
  } pwm_cfg_t;
endpackage

// File: rtl/pwm_ctl_regs.sv
module pwm_ctl_regs
  import pwm_shadow_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              commit,
  output pwm_cfg_t          shadow,
  output logic              en,
  output logic              pend,
  output logic [WORD_W-1:0] rd_data
);
  logic unused_rsv;
  assign unused_rsv = wr_data[RSV_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow <= '0;
      en     <= 1'b0;
      pend   <= 1'b0;
    end else begin
      pend <= (pend & ~commit) | (wr_en & wr_data[UPD_BIT]);
      if (wr_en) begin
        en         <= wr_data[EN_BIT];
        shadow.pre <= wr_data[PRE_LSB +: PRE_W];
        shadow.hi  <= wr_data[HI_LSB +: HI_W];
        shadow.div <= wr_data[DIV_LSB +: DIV_W];
      end
    end
  end

  always_comb begin
    rd_data                    = '0;
    rd_data[EN_BIT]            = en;
    rd_data[UPD_BIT]           = pend;
    rd_data[PRE_LSB +: PRE_W]  = shadow.pre;
    rd_data[HI_LSB +: HI_W]    = shadow.hi;
    rd_data[DIV_LSB +: DIV_W]  = shadow.div;
  end
endmodule

// File: rtl/pwm_period_gen.sv
module pwm_period_gen
  import pwm_shadow_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     en,
  input  logic     pend,
  input  pwm_cfg_t shadow,
  output logic     commit,
  output logic     pwm_out
);
  pwm_cfg_t         act;
  logic             armed;
  logic [PRE_W-1:0] pcnt;
  logic [DIV_W-1:0] dcnt;
  logic             tick_end;
  logic             boundary;

  assign tick_end = (pcnt == act.pre);
  assign boundary = armed & tick_end & (dcnt == act.div);
  assign commit   = pend & (~en | ~armed | boundary);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act   <= '0;
      armed <= 1'b0;
      pcnt  <= '0;
      dcnt  <= '0;
    end else begin
      if (commit) act <= shadow;
      if (!en) begin
        armed <= 1'b0;
        pcnt  <= '0;
        dcnt  <= '0;
      end else if (!armed) begin
        armed <= 1'b1;
        pcnt  <= '0;
        dcnt  <= '0;
      end else if (tick_end) begin
        pcnt <= '0;
        dcnt <= (dcnt == act.div) ? '0 : dcnt + 1'b1;
      end else begin
        pcnt <= pcnt + 1'b1;
      end
    end
  end

  assign pwm_out = en & armed & (CMP_W'(dcnt) < CMP_W'(act.hi));
endmodule

// File: rtl/pwm_shadow_chan.sv
module pwm_shadow_chan
  import pwm_shadow_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] rd_data,
  output logic              pwm_out
);
  pwm_cfg_t shadow;
  logic     en;
  logic     pend;
  logic     commit;

  pwm_ctl_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .commit  (commit),
    .shadow  (shadow),
    .en      (en),
    .pend    (pend),
    .rd_data (rd_data)
  );

  pwm_period_gen u_gen (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .pend    (pend),
    .shadow  (shadow),
    .commit  (commit),
    .pwm_out (pwm_out)
  );
endmodule

// File: rtl/pwm_shadow_chan_chk.sv
module pwm_shadow_chan_chk
  import pwm_shadow_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [WORD_W-1:0] wr_data,
  input logic [WORD_W-1:0] rd_data,
  input logic              pwm_out,
  input logic              en,
  input logic              pend,
  input logic              commit
);
  assert_reset_clear_R9: assert property (@(posedge clk)
    !rst_n |=> (rd_data == '0) && !pwm_out);

  assert_rsv_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[RSV_BIT] == 1'b0);

  assert_shadow_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (rd_data[PRE_LSB +: PRE_W] == $past(wr_data[PRE_LSB +: PRE_W]))
           && (rd_data[HI_LSB +: HI_W] == $past(wr_data[HI_LSB +: HI_W]))
           && (rd_data[DIV_LSB +: DIV_W] == $past(wr_data[DIV_LSB +: DIV_W]))
           && (rd_data[EN_BIT] == $past(wr_data[EN_BIT])));

  assert_off_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[EN_BIT]) |=> !pwm_out);

  assert_idle_commit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !en && !(wr_en && wr_data[UPD_BIT])) |=> !rd_data[UPD_BIT]);

  assert_pend_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !commit) |=> rd_data[UPD_BIT]);
endmodule

bind pwm_shadow_chan pwm_shadow_chan_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en   (wr_en),
  .wr_data (wr_data),
  .rd_data (rd_data),
  .pwm_out (pwm_out),
  .en      (en),
  .pend    (pend),
  .commit  (commit)
);

// File: tb/pwm_shadow_chan_test.sv
module pwm_shadow_chan_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        pwm_out;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  bit cmp_on = 1'b0;
  string tag = "R9";

  // behavioural reference state
  int m_en, m_pend, m_started, m_pos;
  int s_pre, s_hi, s_div, a_pre, a_hi, a_div;

  always #5 clk = ~clk;

  pwm_shadow_chan uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .pwm_out(pwm_out)
  );

  function automatic logic [31:0] word(int en, int upd, int pre, int hi, int dv);
    logic [31:0] w;
    w = '0;
    w[31] = en[0];
    w[30] = upd[0];
    w[29:22] = pre[7:0];
    w[20:10] = hi[10:0];
    w[9:0] = dv[9:0];
    return w;
  endfunction

  function automatic int m_out();
    if (m_en == 0 || m_started == 0) return 0;
    return (m_pos / (a_pre + 1) < a_hi) ? 1 : 0;
  endfunction

  always @(posedge clk) begin
    int per;
    int cm;
    if (!rst_n) begin
      m_en = 0; m_pend = 0; m_started = 0; m_pos = 0;
      s_pre = 0; s_hi = 0; s_div = 0; a_pre = 0; a_hi = 0; a_div = 0;
    end else begin
      per = (a_pre + 1) * (a_div + 1);
      cm = (m_pend != 0) && (m_en == 0 || m_started == 0 || m_pos == per - 1);
      if (m_en == 0) begin
        m_started = 0; m_pos = 0;
      end else if (m_started == 0) begin
        m_started = 1; m_pos = 0;
      end else begin
        m_pos = (m_pos == per - 1) ? 0 : m_pos + 1;
      end
      if (cm) begin a_pre = s_pre; a_hi = s_hi; a_div = s_div; end
      m_pend = (m_pend != 0 && !cm) || (wr_en && wr_data[30]);
      if (wr_en) begin
        m_en = wr_data[31];
        s_pre = wr_data[29:22]; s_hi = wr_data[20:10]; s_div = wr_data[9:0];
      end
    end
  end

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) begin
      chk(rd_data == word(m_en, m_pend, s_pre, s_hi, s_div), tag,
          rd_data, word(m_en, m_pend, s_pre, s_hi, s_div));
      chk(pwm_out == m_out()[0], tag, {31'b0, pwm_out}, m_out());
    end
  end

  task automatic wr(logic [31:0] w);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = w;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(rd_data == 32'h0 && pwm_out == 1'b0, "R9 reset state", {rd_data[31:1], pwm_out}, 32'h0);
    rst_n = 1'b1;
    cmp_on = 1'b1;

    // shadow write only, channel stays off
    tag = "R3 R4";
    wr(word(0, 0, 5, 7, 9));
    chk(rd_data == 32'h0140_1C09, "R3 field placement", rd_data, 32'h0140_1C09);
    chk(pwm_out == 1'b0, "R4 off after shadow write", {31'b0, pwm_out}, 0);
    run(3);

    // enable with update: pre=1 div=3 hi=2 -> 8 cycle period, 4 high
    tag = "R8 R1 R2";
    wr(word(1, 1, 1, 2, 3));
    chk(pwm_out == 1'b0, "R8 first cycle after start write", {31'b0, pwm_out}, 0);
    @(negedge clk);
    for (int i = 0; i < 16; i++) begin
      chk(pwm_out == ((i % 8) < 4), "R1 R2 period pattern", {31'b0, pwm_out}, ((i % 8) < 4));
      @(negedge clk);
    end

    // new shadow without update must not change timing
    tag = "R4";
    wr(word(1, 0, 0, 1, 5));
    run(20);

    // update while running: commits at boundary
    tag = "R5 R6";
    wr(word(1, 1, 0, 1, 5));
    chk(rd_data[30] == 1'b1, "R6 update reads pending", {31'b0, rd_data[30]}, 1);
    run(12);
    chk(rd_data[30] == 1'b0, "R6 update consumed", {31'b0, rd_data[30]}, 0);
    run(12);

    // non-cancelling update: pre=3 div=7 gives a long period
    tag = "R6";
    wr(word(1, 1, 3, 4, 7));
    run(40);
    wr(word(1, 1, 2, 0, 2));
    wr(word(1, 0, 2, 0, 2));
    chk(rd_data[30] == 1'b1, "R6 zero write keeps pending", {31'b0, rd_data[30]}, 1);
    run(40);

    // hi=0: always low
    tag = "R2";
    wr(word(1, 1, 1, 0, 2));
    run(8);
    for (int i = 0; i < 12; i++) begin
      chk(pwm_out == 1'b0, "R2 hi zero stays low", {31'b0, pwm_out}, 0);
      @(negedge clk);
    end

    // hi at maximum: always high
    wr(word(1, 1, 1, 2047, 2));
    run(8);
    for (int i = 0; i < 12; i++) begin
      chk(pwm_out == 1'b1, "R2 hi max stays high", {31'b0, pwm_out}, 1);
      @(negedge clk);
    end

    // disable with pending update
    tag = "R7";
    wr(word(1, 1, 2, 3, 4));
    wr(word(0, 0, 2, 3, 4));
    chk(pwm_out == 1'b0, "R7 low after disable", {31'b0, pwm_out}, 0);
    @(negedge clk);
    chk(rd_data[30] == 1'b0, "R7 update committed while off", {31'b0, rd_data[30]}, 0);
    run(6);

    // restart without update uses committed values, then reset mid run
    tag = "R7 R1";
    wr(word(1, 0, 2, 3, 4));
    run(30);
    tag = "R9";
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(rd_data == 32'h0 && pwm_out == 1'b0, "R9 reset mid run", {rd_data[31:1], pwm_out}, 0);
    rst_n = 1'b1;
    run(4);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule